// File: doc/BRIEF.md
# Frame Scanout Fetch Engine

This block streams one display frame out of memory. Software sets a frame region as a start byte address and an inclusive last byte address, picks a burst length and a FIFO fill threshold, then raises the raster enable. The engine asks a simple memory read port for bursts of words, one word per returned beat, and pushes each word into an output FIFO. The display side pulls words out of the FIFO. When the word that holds the last byte has been fetched, the engine flags end of frame and starts again at the start address.

The start and last addresses are written together in one wide write into a shadow pair. The active pair is loaded from the shadow pair only when a frame begins, so a frame in progress never mixes an old start with a new end. A second fetch mode loads a fixed 32-byte colour table from the start address instead of pixel data. It runs once, sets its own status flag and then waits for the raster enable to drop. Three sticky status flags (table loaded, end of frame, FIFO underflow) are each masked by an enable bit to form a single interrupt line.

Top module: `scan_dma`

## Requirements
- R1: After reset the engine makes no memory request, pixValid is low, status is 0 and irq is low.
- R2: In pixel mode (paletteMode=0) the engine fetches every word from the start address up to and including the word holding the last byte, in rising address order, and presents them on pixData in that order.
- R3: When the last word of a frame arrives, status bit 1 (end of frame) is set and fetching resumes at the start address without software action.
- R4: burstCode 0,1,2,3,4 selects bursts of 1,2,4,8,16 words; the final burst of a region is shortened to the words remaining; burstCode 5, 6 or 7 produces no memory request.
- R5: One write with addrWrEn loads the start address from addrWrData[31:0] and the last-byte address from addrWrData[63:32] into a shadow pair; the pair takes effect only at the next frame start, and the frame in progress completes with the old pair.
- R6: In table mode (paletteMode=1) the engine fetches exactly 32 bytes (8 words) from the start address, then sets status bit 0 and makes no further request until rasterEn has been cleared.
- R7: After rasterEn rises, pixValid stays low until the FIFO has held at least 2*(fifoThresh+1) words; after that it is high whenever the FIFO is not empty.
- R8: A pixRd pulse while the FIFO is empty sets status bit 2 (underflow).
- R9: Status bits stay set until a 1 is written to the same bit of statClr; irq is high exactly when some status bit and its intEn bit are both set.
- R10: Clearing rasterEn lets the burst in flight finish but starts no new request; pixValid is low from the next cycle on.
- R11: memReq, memAddr and memBurst hold steady until memGnt; a burst is requested only when the FIFO has room for all of its words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrWrEn | input | 1 | Write strobe for the shadow address pair |
| addrWrData | input | 64 | Last-byte address in 63:32, start address in 31:0 |
| rasterEn | input | 1 | Run enable |
| paletteMode | input | 1 | 1 = 32-byte table fetch, 0 = pixel fetch |
| burstCode | input | 3 | Burst length select (0..4 valid) |
| fifoThresh | input | 3 | FIFO fill level needed before output starts |
| intEn | input | 3 | Per-status interrupt enables |
| statClr | input | 3 | Write-1-to-clear for status bits |
| memReq | output | 1 | Burst read request |
| memAddr | output | 32 | Byte address of the first word of the burst |
| memBurst | output | 5 | Words in the requested burst |
| memGnt | input | 1 | Request accepted |
| memRvalid | input | 1 | Returned word valid |
| memRdata | input | 32 | Returned word |
| pixRd | input | 1 | Display side takes one word |
| pixValid | output | 1 | A word is available on pixData |
| pixData | output | 32 | Head word of the FIFO |
| status | output | 3 | Sticky flags: 0 table loaded, 1 end of frame, 2 underflow |
| irq | output | 1 | Interrupt |

## Verification
The bench targets frame wrap, a final burst shorter than the selected length, an address write landing mid-frame, the table-mode stop and a raster disable arriving mid-burst. A design that shortened bursts wrongly would read past the last byte or stall waiting for beats that never come, while one that loaded addresses straight into the active pair would splice the new region into the current frame. A design that aborted a burst on disable would leave returned beats unconsumed, and one that kept fetching after the table would flood the FIFO. The threshold and underflow cases catch output released before the fill level or an underflow flag that never sets.

// File: rtl/scan_dma_pkg.sv
`timescale 1ns/1ps
package scan_dma_pkg;
  localparam int MAX_BURST = 16;
  localparam int BLEN_W = $clog2(MAX_BURST + 1);

  localparam int STAT_PAL = 0;
  localparam int STAT_EOF = 1;
  localparam int STAT_UND = 2;
  localparam int STAT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_REQ, ST_DATA, ST_PDONE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic flush;
    logic pushBeat;
    logic setPal;
    logic setEof;
  } dmaStrobe_t;

  // 0..4 -> 1..16 words, anything else -> 0 (not allowed)
  function automatic logic [BLEN_W-1:0] burstWords(input logic [2:0] code);
    if (code <= 3'd4) burstWords = BLEN_W'(1) << code;
    else burstWords = '0;
  endfunction
endpackage

// File: rtl/scan_dma_dp.sv
`timescale 1ns/1ps
module scan_dma_dp
  import scan_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FIFO_DEPTH = 16,  // power of two
  parameter int PAL_BYTES = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dmaStrobe_t                 st,
  input  logic                       addrWrEn,
  input  logic [2*ADDR_W-1:0]        addrWrData,
  input  logic                       paletteMode,
  input  logic [2:0]                 burstCode,
  input  logic [2:0]                 fifoThresh,
  input  logic                       rasterEn,
  input  logic [DATA_W-1:0]          memRdata,
  input  logic                       pixRd,
  input  logic [STAT_W-1:0]          statClr,
  input  logic [STAT_W-1:0]          intEn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [BLEN_W-1:0]          memBurst,
  output logic                       lastBurst,
  output logic                       roomOk,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel,
  output logic                       pixValid,
  output logic [DATA_W-1:0]          pixData,
  output logic [STAT_W-1:0]          status,
  output logic                       irq
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(WORD_BYTES);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int THR_STEP = (FIFO_DEPTH / 8 > 0) ? FIFO_DEPTH / 8 : 1;

  // shadow and active region registers
  logic [ADDR_W-1:0] shadowBase, shadowLast, actBase, actLast, curAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowBase <= '0;
      shadowLast <= '0;
    end else if (addrWrEn) begin
      shadowBase <= addrWrData[ADDR_W-1:0];
      shadowLast <= addrWrData[2*ADDR_W-1:ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actBase <= '0;
      actLast <= '0;
      curAddr <= '0;
    end else if (st.startFrame) begin
      actBase <= shadowBase;
      actLast <= shadowLast;
      curAddr <= shadowBase;
    end else if (st.pushBeat) begin
      curAddr <= curAddr + ADDR_W'(WORD_BYTES);
    end
  end

  // words left in the region and the length of the next burst
  logic [ADDR_W-1:0] endAddr, byteSpan, wordsLeft, burstExt;
  logic [BLEN_W-1:0] burstLen;

  always_comb begin
    burstLen  = burstWords(burstCode);
    endAddr   = paletteMode ? actBase + ADDR_W'(PAL_BYTES - 1) : actLast;
    byteSpan  = endAddr - curAddr;
    wordsLeft = (byteSpan >> OFF_W) + ADDR_W'(1);
    burstExt  = ADDR_W'(burstLen);
    lastBurst = wordsLeft <= burstExt;
    memBurst  = lastBurst ? wordsLeft[BLEN_W-1:0] : burstLen;
    memAddr   = curAddr;
  end

  // output FIFO
  logic [DATA_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCount, fifoFree;
  logic              armed, doPop, fifoEmpty, reachLevel;

  assign fifoEmpty = (fifoCount == '0);
  assign pixValid  = armed && !fifoEmpty;
  assign doPop     = pixRd && pixValid;
  assign pixData   = fifoMem[rdPtr];
  assign fifoLevel = fifoCount;
  assign fifoFree  = CNT_W'(FIFO_DEPTH) - fifoCount;
  assign roomOk    = int'(fifoFree) >= int'(memBurst);

  always_comb begin
    int lvl;
    lvl = (int'(fifoThresh) + 1) * THR_STEP;
    if (lvl > FIFO_DEPTH) lvl = FIFO_DEPTH;
    reachLevel = int'(fifoCount) >= lvl;
  end

  always_ff @(posedge clk) begin
    if (st.pushBeat) fifoMem[wrPtr] <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (st.pushBeat) wrPtr <= wrPtr + 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
      case ({st.pushBeat, doPop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rasterEn) armed <= 1'b0;
    else if (reachLevel) armed <= 1'b1;
  end

  // sticky status, write one to clear, set wins
  logic [STAT_W-1:0] setVec;
  always_comb begin
    setVec = '0;
    setVec[STAT_PAL] = st.setPal;
    setVec[STAT_EOF] = st.setEof;
    setVec[STAT_UND] = pixRd && fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else status <= (status & ~statClr) | setVec;
  end

  assign irq = |(status & intEn);
endmodule

// File: rtl/scan_dma_ctrl.sv
`timescale 1ns/1ps
module scan_dma_ctrl
  import scan_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasterEn,
  input  logic              paletteMode,
  input  logic [2:0]        burstCode,
  input  logic              roomOk,
  input  logic              lastBurst,
  input  logic [BLEN_W-1:0] memBurst,
  input  logic              memGnt,
  input  logic              memRvalid,
  output logic              memReq,
  output dmaStrobe_t        st
);
  ctrlState_t        state, nextState;
  logic [BLEN_W-1:0] beatsLeft;
  logic              lastReg, burstOk;

  assign burstOk = burstWords(burstCode) != '0;

  always_comb begin
    st        = '0;
    memReq    = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (rasterEn && burstOk) begin
          st.startFrame = 1'b1;
          st.flush      = 1'b1;
          nextState     = ST_ARB;
        end
      end
      ST_ARB: begin
        if (!rasterEn) nextState = ST_IDLE;
        else if (burstOk && roomOk) nextState = ST_REQ;
      end
      ST_REQ: begin
        memReq = 1'b1;
        if (memGnt) nextState = ST_DATA;
      end
      ST_DATA: begin
        if (memRvalid) begin
          st.pushBeat = 1'b1;
          if (beatsLeft == BLEN_W'(1)) begin
            if (lastReg && paletteMode) begin
              st.setPal = 1'b1;
              nextState = ST_PDONE;
            end else begin
              if (lastReg) begin
                st.setEof     = 1'b1;
                st.startFrame = 1'b1;
              end
              nextState = rasterEn ? ST_ARB : ST_IDLE;
            end
          end
        end
      end
      ST_PDONE: begin
        if (!rasterEn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
      lastReg   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_REQ && memGnt) begin
        beatsLeft <= memBurst;
        lastReg   <= lastBurst;
      end else if (state == ST_DATA && memRvalid) begin
        beatsLeft <= beatsLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_dma.sv
`timescale 1ns/1ps
module scan_dma
  import scan_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int PAL_BYTES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                addrWrEn,
  input  logic [2*ADDR_W-1:0] addrWrData,
  input  logic                rasterEn,
  input  logic                paletteMode,
  input  logic [2:0]          burstCode,
  input  logic [2:0]          fifoThresh,
  input  logic [2:0]          intEn,
  input  logic [2:0]          statClr,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [4:0]          memBurst,
  input  logic                memGnt,
  input  logic                memRvalid,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                pixRd,
  output logic                pixValid,
  output logic [DATA_W-1:0]   pixData,
  output logic [2:0]          status,
  output logic                irq
);
  dmaStrobe_t st;
  logic       lastBurst, roomOk;
  logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel;

  scan_dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .paletteMode(paletteMode),
    .burstCode(burstCode), .roomOk(roomOk), .lastBurst(lastBurst),
    .memBurst(memBurst), .memGnt(memGnt), .memRvalid(memRvalid),
    .memReq(memReq), .st(st)
  );

  scan_dma_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .PAL_BYTES(PAL_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .paletteMode(paletteMode), .burstCode(burstCode), .fifoThresh(fifoThresh),
    .rasterEn(rasterEn), .memRdata(memRdata), .pixRd(pixRd), .statClr(statClr),
    .intEn(intEn), .memAddr(memAddr), .memBurst(memBurst), .lastBurst(lastBurst),
    .roomOk(roomOk), .fifoLevel(fifoLevel), .pixValid(pixValid), .pixData(pixData),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/scan_dma_chk.sv
`timescale 1ns/1ps
module scan_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int FIFO_DEPTH = 16
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             rasterEn,
  input logic                             paletteMode,
  input logic                             memReq,
  input logic                             memGnt,
  input logic [ADDR_W-1:0]                memAddr,
  input logic [4:0]                       memBurst,
  input logic                             pixValid,
  input logic [2:0]                       status,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  fifoLevel
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memBurst));

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBurst != 5'd0) && (memBurst <= 5'd16));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoLevel) <= FIFO_DEPTH);

  assert_stop_output_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rasterEn |=> !pixValid);

  assert_pal_flag_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> paletteMode);

  assert_eof_flag_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> !paletteMode);
endmodule

bind scan_dma scan_dma_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .paletteMode(paletteMode),
  .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr), .memBurst(memBurst),
  .pixValid(pixValid), .status(status), .fifoLevel(fifoLevel)
);

// File: tb/tb_scan_dma.sv
`timescale 1ns/1ps
module tb_scan_dma;
  logic        clk = 1'b0;
  logic        rstN;
  logic        addrWrEn;
  logic [63:0] addrWrData;
  logic        rasterEn, paletteMode;
  logic [2:0]  burstCode, fifoThresh, intEn, statClr;
  logic        memReq;
  logic [31:0] memAddr;
  logic [4:0]  memBurst;
  logic        memGnt, memRvalid;
  logic [31:0] memRdata;
  logic        pixRd, pixValid;
  logic [31:0] pixData;
  logic [2:0]  status;
  logic        irq;

  always #10 clk = ~clk;

  scan_dma dut (
    .clk(clk), .rstN(rstN), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .rasterEn(rasterEn), .paletteMode(paletteMode), .burstCode(burstCode),
    .fifoThresh(fifoThresh), .intEn(intEn), .statClr(statClr),
    .memReq(memReq), .memAddr(memAddr), .memBurst(memBurst), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata), .pixRd(pixRd),
    .pixValid(pixValid), .pixData(pixData), .status(status), .irq(irq)
  );

  int checks = 0;
  int failures = 0;

  // memory model state and logs
  int          rspLeft, burstCnt, beatsSent, pixCnt;
  logic [31:0] rspAddr;
  logic [31:0] burstLog [32];
  logic [31:0] addrLog [32];
  logic [31:0] pixLog [64];
  bit          autoRead, forceRd;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder: grant on request, then one beat per cycle
  initial begin
    memGnt = 0; memRvalid = 0; memRdata = '0;
    forever begin
      @(negedge clk);
      memGnt = 0; memRvalid = 0;
      if (rspLeft > 0) begin
        memRvalid = 1; memRdata = rspAddr;
        rspAddr += 32'd4; rspLeft--; beatsSent++;
      end else if (memReq && rstN) begin
        memGnt = 1; rspAddr = memAddr; rspLeft = int'(memBurst);
        if (burstCnt < 32) begin
          burstLog[burstCnt] = 32'(memBurst);
          addrLog[burstCnt] = memAddr;
        end
        burstCnt++;
      end
    end
  end

  // display-side reader
  initial begin
    pixRd = 0;
    forever begin
      @(negedge clk);
      if (autoRead && pixValid) begin
        pixRd = 1;
        if (pixCnt < 64) pixLog[pixCnt] = pixData;
        pixCnt++;
      end else pixRd = forceRd;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; addrWrEn = 0; addrWrData = '0; rasterEn = 0; paletteMode = 0;
    burstCode = 0; fifoThresh = 0; intEn = 0; statClr = 0;
    autoRead = 0; forceRd = 0;
    rspLeft = 0; burstCnt = 0; beatsSent = 0; pixCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic setRegion(input logic [31:0] base, input logic [31:0] last);
    @(negedge clk);
    addrWrEn = 1; addrWrData = {last, base};
    @(negedge clk);
    addrWrEn = 0;
  endtask

  task automatic waitPix(input int n);
    for (int i = 0; i < 3000 && pixCnt < n; i++) @(negedge clk);
  endtask

  task automatic waitBursts(input int n);
    for (int i = 0; i < 3000 && burstCnt < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk(memReq == 0, "R1 memReq idle", memReq, 0);
    chk(pixValid == 0, "R1 pixValid idle", pixValid, 0);
    chk(status == 0 && irq == 0, "R1 status/irq", {status, irq}, 0);
  endtask

  task automatic tDataFrame();
    doReset();
    setRegion(32'h1000, 32'h101F);
    burstCode = 3'd2; autoRead = 1; rasterEn = 1;
    waitPix(12);
    for (int i = 0; i < 12; i++)
      chk(pixLog[i] == 32'h1000 + 32'(4 * (i % 8)), i < 8 ? "R2 word order" : "R3 wrap words",
          pixLog[i], 32'h1000 + 4 * (i % 8));
    chk(status[1] == 1, "R3 end of frame flag", status[1], 1);
    chk(burstLog[1] == 4 && addrLog[1] == 32'h1010, "R4 second burst", addrLog[1], 32'h1010);
    chk(addrLog[2] == 32'h1000, "R3 restart address", addrLog[2], 32'h1000);
    rasterEn = 0; autoRead = 0;
  endtask

  task automatic tClip();
    doReset();
    setRegion(32'h1000, 32'h1017);
    burstCode = 3'd2; rasterEn = 1;
    waitBursts(3);
    chk(burstLog[0] == 4, "R4 full burst", burstLog[0], 4);
    chk(burstLog[1] == 2 && addrLog[1] == 32'h1010, "R4 clipped burst", burstLog[1], 2);
    chk(burstLog[2] == 4 && addrLog[2] == 32'h1000, "R4 burst after wrap", burstLog[2], 4);
    doReset();
    setRegion(32'h1000, 32'h1017);
    burstCode = 3'd3; autoRead = 1; rasterEn = 1;
    waitBursts(2);
    chk(burstLog[0] == 6 && burstLog[1] == 6, "R4 eight clipped to six", burstLog[0], 6);
    rasterEn = 0; autoRead = 0;
  endtask

  task automatic tInvalid();
    doReset();
    setRegion(32'h1000, 32'h10FF);
    burstCode = 3'd5; rasterEn = 1;
    repeat (40) @(negedge clk);
    chk(burstCnt == 0 && memReq == 0, "R4 bad code no request", burstCnt, 0);
    burstCode = 3'd7;
    repeat (20) @(negedge clk);
    chk(burstCnt == 0, "R4 code 7 no request", burstCnt, 0);
    rasterEn = 0;
  endtask

  task automatic tShadow();
    doReset();
    setRegion(32'h1000, 32'h103F);
    burstCode = 3'd0; autoRead = 1; rasterEn = 1;
    waitPix(3);
    setRegion(32'h2000, 32'h2007);
    waitPix(19);
    chk(pixLog[4] == 32'h1010, "R5 frame keeps old start", pixLog[4], 32'h1010);
    chk(pixLog[15] == 32'h103C, "R5 frame keeps old end", pixLog[15], 32'h103C);
    chk(pixLog[16] == 32'h2000, "R5 new start at next frame", pixLog[16], 32'h2000);
    chk(pixLog[17] == 32'h2004 && pixLog[18] == 32'h2000, "R5 new end used", pixLog[18], 32'h2000);
    rasterEn = 0; autoRead = 0;
  endtask

  task automatic tPalette();
    doReset();
    setRegion(32'h3000, 32'h30FF);
    paletteMode = 1; burstCode = 3'd2; intEn = 3'b001; rasterEn = 1;
    repeat (200) @(negedge clk);
    chk(beatsSent == 8, "R6 exactly eight words", beatsSent, 8);
    chk(burstCnt == 2 && addrLog[1] == 32'h3010, "R6 two bursts", burstCnt, 2);
    chk(status == 3'b001, "R6 table flag only", status, 3'b001);
    chk(irq == 1, "R9 irq from enabled flag", irq, 1);
    statClr = 3'b001;
    @(negedge clk);
    statClr = 3'b000;
    chk(status[0] == 0 && irq == 0, "R9 write one clears", status, 0);
    rasterEn = 0;
    repeat (3) @(negedge clk);
    rasterEn = 1;
    repeat (60) @(negedge clk);
    chk(beatsSent == 16, "R6 reruns after enable toggle", beatsSent, 16);
    rasterEn = 0;
  endtask

  task automatic tUnderflow();
    doReset();
    forceRd = 1;
    @(negedge clk);
    forceRd = 0;
    @(negedge clk);
    chk(status[2] == 1, "R8 underflow flag", status, 3'b100);
    chk(irq == 0, "R9 masked flag no irq", irq, 0);
    intEn = 3'b100;
    #1;
    chk(irq == 1, "R9 unmasked flag irq", irq, 1);
    @(negedge clk);
    chk(status[2] == 1, "R9 flag sticky", status, 3'b100);
    statClr = 3'b100;
    @(negedge clk);
    statClr = 3'b000;
    chk(status == 0 && irq == 0, "R9 clear underflow", status, 0);
  endtask

  task automatic tStop();
    doReset();
    setRegion(32'h1000, 32'h10FF);
    burstCode = 3'd4; rasterEn = 1;
    waitBursts(1);
    @(negedge clk);
    rasterEn = 0;
    repeat (60) @(negedge clk);
    chk(beatsSent == 16, "R10 burst in flight completes", beatsSent, 16);
    chk(burstCnt == 1 && memReq == 0, "R10 no new request", burstCnt, 1);
    chk(pixValid == 0, "R10 output stopped", pixValid, 0);
  endtask

  task automatic tThreshold();
    bit early = 0;
    doReset();
    setRegion(32'h1000, 32'h10FF);
    burstCode = 3'd0; fifoThresh = 3'd3; rasterEn = 1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (pixValid && beatsSent < 8) early = 1;
    end
    chk(!early, "R7 no output before level", early, 0);
    chk(pixValid == 1, "R7 output after level", pixValid, 1);
    chk(beatsSent == 16 && memReq == 0, "R11 stops when FIFO full", beatsSent, 16);
    autoRead = 1;
    waitPix(2);
    chk(pixLog[0] == 32'h1000 && pixLog[1] == 32'h1004, "R7 drain order", pixLog[1], 32'h1004);
    rasterEn = 0; autoRead = 0;
  endtask

  bit finished = 0;

  initial begin
    rstN = 0;
    tReset();
    tDataFrame();
    tClip();
    tInvalid();
    tShadow();
    tPalette();
    tUnderflow();
    tStop();
    tThreshold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule